// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block is a fully associative cache of page translations. It turns the virtual page number of a 32-bit address into a physical page frame, using 4 KB pages. Every entry carries a small process-identifier tag and a global flag. Entries belonging to several address spaces can therefore sit in the cache together. Because of this, a context switch only changes the current process ID that is presented with each lookup; it does not force a flush.

A lookup is combinational. The address and the current process ID go in, and hit, miss and the physical address come out in the same cycle. After a table walk, a fill port writes one entry per clock. A control port flushes either every entry or only the non-global entries of one process.

A build parameter selects an untagged variant. That variant has no process field, treats every entry as matching every process, and is meant to be flushed in full at each context switch. The recommended sizes are 64 entries with 3-bit tags for the tagged build, and 22 entries for the untagged build.

Top module: `xlat_cache`

## Requirements
- R1: A lookup key is `lk_va[31:12]`. On a hit, `lk_pa` equals `{ppn, lk_va[11:0]}` in the same cycle. When several entries match, the lowest-indexed one supplies the frame.
- R2: When `lk_req` is high and no entry matches, `lk_miss` is 1, `lk_hit` is 0 and `lk_pa` is 0. When `lk_req` is low, `lk_hit`, `lk_miss` and `lk_pa` are all 0.
- R3: In the tagged build, a valid entry whose global flag is 0 matches only when its stored tag equals `lk_pid`.
- R4: A valid entry whose global flag is 1 matches for every value of `lk_pid`. It still occupies its own slot.
- R5: An accepted fill overwrites an existing valid entry when that entry has the same page number and the same scope. Same scope means both entries are global, or both are non-global with equal tags.
- R6: Otherwise, an accepted fill goes to the lowest-indexed invalid slot.
- R7: When every slot is valid and no entry is overwritten, the fill replaces the slot named by a round-robin pointer. The pointer advances by one, wrapping at the last slot, only when it is used this way.
- R8: `flush_pid_en` clears the valid bit of every non-global entry whose tag equals `flush_pid`. It leaves global entries and entries of other processes intact.
- R9: `flush_all` clears every entry, including global ones.
- R10: A fill presented in the same cycle as any flush is discarded. When `flush_all` and `flush_pid_en` are both high, `flush_all` prevails.
- R11: In the untagged build (`TAGGED=0`), lookups and fills ignore the process ID and the global flag. Fill overwrite is decided by page number alone, and `flush_pid_en` clears every entry.
- R12: After reset, all entries are invalid and the round-robin pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_pid | input | PID_W | Current process ID |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup found no entry |
| lk_pa | output | PA_W | Translated physical address, 0 when there is no hit |
| fill_en | input | 1 | Write a new translation |
| fill_vpn | input | VA_W-PAGE_BITS | Page number of the new translation |
| fill_ppn | input | PA_W-PAGE_BITS | Frame number of the new translation |
| fill_pid | input | PID_W | Process tag of the new translation |
| fill_global | input | 1 | New translation matches every process |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate the non-global entries of one process |
| flush_pid | input | PID_W | Process whose entries are flushed |

## Verification
The bench builds a tagged instance with 4 entries and 2-bit tags, and an untagged instance with 3 entries; both receive the same stimulus. With only four slots, a handful of fills reaches the full state, so the round-robin victim path, including its wrap, is exercised alongside the free-slot and overwrite paths. After every fill or flush, each of the 4 process IDs is swept against every page number held in the cache, plus one absent page. That sweep covers tag isolation, global sharing, lowest-index priority and the effect of selective flushes completely. The small untagged instance shows overwrite by page number alone and the full clear on a process flush.

// File: rtl/xlat_pkg.sv
// Package: shared types for the translation cache.
// Assumes: nothing; imported by every module of the block.
package xlat_pkg;
    // Where an accepted fill lands.
    typedef enum logic [1:0] {
        SRC_MATCH  = 2'd0,   // overwrite an entry with the same key and scope
        SRC_FREE   = 2'd1,   // lowest invalid slot
        SRC_VICTIM = 2'd2    // round-robin replacement
    } slot_src_e;
endpackage

// File: rtl/xlat_match.sv
// Module: parallel comparison of one key against every cache entry.
// Reports whether any entry matched and the lowest matching index.
// STRICT=0 gives lookup semantics: a global entry matches any process.
// STRICT=1 gives fill-overwrite semantics: the scope must be equal.
// Assumes: arrays are indexed by slot; TAGGED=0 ignores pid and glb.
module xlat_match #(
    parameter int N      = 64,
    parameter int VPN_W  = 20,
    parameter int PID_W  = 3,
    parameter int IDX_W  = 6,
    parameter bit TAGGED = 1'b1,
    parameter bit STRICT = 1'b0
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][VPN_W-1:0]  vpn,
    input  logic [N-1:0][PID_W-1:0]  pid,
    input  logic [N-1:0]             glb,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [PID_W-1:0]         key_pid,
    input  logic                     key_glb,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx
);
    logic [N-1:0] eq;

    // Per-entry comparators; the scope rule is chosen by parameters.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic scope_ok;
        if (!TAGGED) begin : g_flat
            assign scope_ok = 1'b1;
        end else if (STRICT) begin : g_strict
            assign scope_ok = (glb[i] == key_glb) && (key_glb || (pid[i] == key_pid));
        end else begin : g_lookup
            assign scope_ok = glb[i] || (pid[i] == key_pid);
        end
        assign eq[i] = valid[i] && (vpn[i] == key_vpn) && scope_ok;
    end

    // Inputs that a given variant does not consult.
    logic unused_inputs;
    assign unused_inputs = ^{key_glb, key_pid, pid, glb};

    // Lowest-index priority encoder over the match vector.
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
// Module: chooses the slot written by an accepted fill and owns the
// round-robin replacement pointer.
// Order of preference: overwrite a matching entry, then the lowest
// invalid slot, then the pointer's slot.
// Assumes: commit is high only in cycles when the fill is really written.
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             dup_hit,
    input  logic [IDX_W-1:0] dup_idx,
    input  logic             commit,
    output logic [IDX_W-1:0] slot,
    output slot_src_e        src
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic             adv;

    // Find the lowest invalid slot.
    always_comb begin
        free_any = ~&valid;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Pick the destination by preference order.
    always_comb begin
        if (dup_hit) begin
            src  = SRC_MATCH;
            slot = dup_idx;
        end else if (free_any) begin
            src  = SRC_FREE;
            slot = free_idx;
        end else begin
            src  = SRC_VICTIM;
            slot = rr_q;
        end
    end

    assign adv = commit && (src == SRC_VICTIM);

    // Advance the pointer only when it supplied the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)      rr_q <= '0;
        else if (adv)    rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end

    // R7
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(rr_q));

    // R6
    victim_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && src == SRC_VICTIM) |-> (&valid && !dup_hit));
endmodule

// File: rtl/xlat_cache.sv
// Module: fully associative, process-tagged page translation cache.
// Lookup is combinational; fills and flushes take effect at the clock edge.
// Assumes: 4 KB pages by default, at most one fill per cycle, and that
// flushes win over a fill in the same cycle. TAGGED=0 builds the untagged
// variant, whose entries carry no process tag.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 64,
    parameter int PID_W     = 3,
    parameter bit TAGGED    = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lk_req,
    input  logic [VA_W-1:0]           lk_va,
    input  logic [PID_W-1:0]          lk_pid,
    output logic                      lk_hit,
    output logic                      lk_miss,
    output logic [PA_W-1:0]           lk_pa,
    input  logic                      fill_en,
    input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
    input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
    input  logic [PID_W-1:0]          fill_pid,
    input  logic                      fill_global,
    input  logic                      flush_all,
    input  logic                      flush_pid_en,
    input  logic [PID_W-1:0]          flush_pid
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0]             glb_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][PID_W-1:0]  pid_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;

    logic             lk_any;
    logic [IDX_W-1:0] lk_idx;
    logic             dup_hit;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] slot;
    slot_src_e        src;
    logic             fill_go;
    logic             any_flush;
    logic [ENTRIES-1:0] pid_sel;
    logic [ENTRIES-1:0] fmask;

    // Lookup comparator: global entries match every process.
    xlat_match #(
        .N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W),
        .TAGGED(TAGGED), .STRICT(1'b0)
    ) u_lk_match (
        .valid(valid_q), .vpn(vpn_q), .pid(pid_q), .glb(glb_q),
        .key_vpn(lk_va[VA_W-1:PAGE_BITS]), .key_pid(lk_pid), .key_glb(1'b0),
        .hit(lk_any), .idx(lk_idx)
    );

    // Fill comparator: finds an entry with equal key and scope.
    xlat_match #(
        .N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W),
        .TAGGED(TAGGED), .STRICT(1'b1)
    ) u_fill_match (
        .valid(valid_q), .vpn(vpn_q), .pid(pid_q), .glb(glb_q),
        .key_vpn(fill_vpn), .key_pid(fill_pid), .key_glb(fill_global),
        .hit(dup_hit), .idx(dup_idx)
    );

    assign any_flush = flush_all || flush_pid_en;
    assign fill_go   = fill_en && !any_flush;

    // Destination slot and replacement pointer.
    xlat_victim #(
        .N(ENTRIES), .IDX_W(IDX_W)
    ) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q),
        .dup_hit(dup_hit), .dup_idx(dup_idx), .commit(fill_go),
        .slot(slot), .src(src)
    );

    // Lookup result; the page offset passes through untouched.
    always_comb begin
        lk_hit  = lk_req && lk_any;
        lk_miss = lk_req && !lk_any;
        lk_pa   = lk_hit ? {ppn_q[lk_idx], lk_va[PAGE_BITS-1:0]} : '0;
    end

    // Entries hit by a process flush (all of them when untagged).
    for (genvar i = 0; i < ENTRIES; i++) begin : g_fsel
        if (TAGGED) begin : g_tag
            assign pid_sel[i] = !glb_q[i] && (pid_q[i] == flush_pid);
        end else begin : g_flat
            assign pid_sel[i] = 1'b1;
        end
        assign fmask[i] = flush_all || (flush_pid_en && pid_sel[i]);
    end

    // Valid bits: flushes clear, accepted fills set.
    always_ff @(posedge clk) begin
        if (!rst_n)          valid_q <= '0;
        else if (any_flush)  valid_q <= valid_q & ~fmask;
        else if (fill_go)    valid_q[slot] <= 1'b1;
    end

    // Translation payload, written by accepted fills.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            vpn_q[slot] <= fill_vpn;
            ppn_q[slot] <= fill_ppn;
        end
    end

    // Process tag and global flag exist only in the tagged build.
    if (TAGGED) begin : g_tags
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pid_q <= '0;
                glb_q <= '0;
            end else if (fill_go) begin
                pid_q[slot] <= fill_pid;
                glb_q[slot] <= fill_global;
            end
        end
    end else begin : g_notags
        assign pid_q = '0;
        assign glb_q = '0;
        logic unused_tags;
        assign unused_tags = ^{fill_pid, fill_global, lk_pid, flush_pid};
    end

    // R9
    flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    // R8
    flush_pid_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pid_en && !flush_all) |=> ((valid_q & $past(pid_sel)) == '0));

    // R5
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |=> (valid_q[$past(slot)] && vpn_q[$past(slot)] == $past(fill_vpn)
                     && ppn_q[$past(slot)] == $past(fill_ppn)));

    // R10
    fill_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && any_flush) |=> ($countones(valid_q) <= $countones($past(valid_q))));
endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;
    localparam int N  = 4;
    localparam int PW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [PW-1:0] lk_pid = '0;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [PW-1:0] fill_pid = '0;
    logic        fill_global = 1'b0;
    logic        flush_all = 1'b0;
    logic        flush_pid_en = 1'b0;
    logic [PW-1:0] flush_pid = '0;

    logic        t_hit, t_miss, u_hit, u_miss;
    logic [31:0] t_pa, u_pa;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    xlat_cache #(.ENTRIES(N), .PID_W(PW), .TAGGED(1'b1)) u_dut (
        .clk, .rst_n, .lk_req, .lk_va, .lk_pid,
        .lk_hit(t_hit), .lk_miss(t_miss), .lk_pa(t_pa),
        .fill_en, .fill_vpn, .fill_ppn, .fill_pid, .fill_global,
        .flush_all, .flush_pid_en, .flush_pid);

    xlat_cache #(.ENTRIES(3), .PID_W(PW), .TAGGED(1'b0)) u_dut_flat (
        .clk, .rst_n, .lk_req, .lk_va, .lk_pid,
        .lk_hit(u_hit), .lk_miss(u_miss), .lk_pa(u_pa),
        .fill_en, .fill_vpn, .fill_ppn, .fill_pid, .fill_global,
        .flush_all, .flush_pid_en, .flush_pid);

    // Reference state for the tagged instance, maintained from the requirements.
    bit        m_v [N];
    bit        m_g [N];
    int        m_vpn [N];
    int        m_pid [N];
    int        m_ppn [N];
    int        m_rr;
    int        sweep_vpn [7] = '{'h10, 'h11, 'h12, 'h13, 'h80, 'h20, 'h7F};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic m_fill(input int vpn, input int pid, input bit g, input int ppn);
        int s = -1;
        for (int i = 0; i < N; i++)
            if (s < 0 && m_v[i] && m_vpn[i] == vpn && m_g[i] == g && (g || m_pid[i] == pid)) s = i;
        for (int i = 0; i < N; i++)
            if (s < 0 && !m_v[i]) s = i;
        if (s < 0) begin
            s = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_v[s] = 1; m_g[s] = g; m_vpn[s] = vpn; m_pid[s] = pid; m_ppn[s] = ppn;
    endtask

    // Drive one cycle of fill and/or flush, then update the model.
    task automatic op(input bit fe, input int vpn, input int pid, input bit g, input int ppn,
                      input bit fa, input bit fp, input int fpid);
        @(negedge clk);
        fill_en = fe; fill_vpn = 20'(vpn); fill_pid = PW'(pid); fill_global = g; fill_ppn = 20'(ppn);
        flush_all = fa; flush_pid_en = fp; flush_pid = PW'(fpid);
        @(negedge clk);
        fill_en = 0; flush_all = 0; flush_pid_en = 0;
        if (fa) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (fp) begin
            for (int i = 0; i < N; i++) if (!m_g[i] && m_pid[i] == fpid) m_v[i] = 0;
        end else if (fe) begin
            m_fill(vpn, pid, g, ppn);
        end
    endtask

    // Lookup every process against every page of interest (R1, R2, R3, R4).
    task automatic sweep();
        for (int p = 0; p < (1 << PW); p++) begin
            for (int k = 0; k < 7; k++) begin
                int    e = -1;
                string tag;
                logic [31:0] ea;
                for (int i = N - 1; i >= 0; i--)
                    if (m_v[i] && m_vpn[i] == sweep_vpn[k] && (m_g[i] || m_pid[i] == p)) e = i;
                lk_req = 1; lk_pid = PW'(p);
                lk_va = {20'(sweep_vpn[k]), 12'(('h5A3 + 37 * k + p) & 'hFFF)};
                #1;
                ea = (e >= 0) ? {20'(m_ppn[e]), lk_va[11:0]} : 32'h0;
                tag = (e < 0) ? "R2 miss" : (m_g[e] ? "R4 global" : "R3/R1 tagged");
                chk({t_hit, t_miss, t_pa} == {e >= 0, e < 0, ea}, tag,
                    {t_hit, t_miss, t_pa}, {(e >= 0), (e < 0), ea});
                @(negedge clk);
            end
        end
        lk_req = 0;
    endtask

    task automatic u_look(input int vpn, input int p, input bit eh, input int eppn, input string req);
        logic [31:0] ea;
        lk_req = 1; lk_pid = PW'(p); lk_va = {20'(vpn), 12'h0C4};
        #1;
        ea = eh ? {20'(eppn), 12'h0C4} : 32'h0;
        chk({u_hit, u_miss, u_pa} == {eh, !eh, ea}, req, {u_hit, u_miss, u_pa}, {eh, !eh, ea});
        @(negedge clk);
        lk_req = 0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: empty after reset
        sweep();
        // R2: idle outputs with no request
        lk_va = {20'h10, 12'h0}; #1;
        chk({t_hit, t_miss, t_pa} == '0, "R2 idle", {t_hit, t_miss, t_pa}, 0);
        @(negedge clk);
        // R6: fill free slots
        op(1, 'h10, 0, 0, 'h100, 0, 0, 0);
        op(1, 'h11, 1, 0, 'h101, 0, 0, 0);
        op(1, 'h12, 2, 0, 'h102, 0, 0, 0);
        op(1, 'h13, 3, 0, 'h103, 0, 0, 0);
        sweep();
        // R7, R12: full, victim is slot 0; global entry R4
        op(1, 'h80, 1, 1, 'h180, 0, 0, 0);
        sweep();
        // R5: same key and scope overwrites, no eviction
        op(1, 'h11, 1, 0, 'h1AA, 0, 0, 0);
        sweep();
        // R7: other process, new victim slot 1
        op(1, 'h11, 2, 0, 'h1BB, 0, 0, 0);
        sweep();
        // R1: non-global twin of global page, lowest index wins
        op(1, 'h80, 0, 0, 'h1CC, 0, 0, 0);
        sweep();
        // R8: flush one process
        op(0, 0, 0, 0, 0, 0, 1, 3);
        sweep();
        // R6: refill into freed slot
        op(1, 'h20, 3, 0, 'h120, 0, 0, 0);
        sweep();
        // R7: pointer wrap through slot 3 then 0
        op(1, 'h12, 2, 0, 'h122, 0, 0, 0);
        op(1, 'h13, 1, 0, 'h133, 0, 0, 0);
        sweep();
        // R10: fill with process flush is discarded
        op(1, 'h7F, 0, 0, 'h1EE, 0, 1, 2);
        sweep();
        // R10, R9: both flushes plus fill, everything cleared
        op(1, 'h7F, 1, 1, 'h1EF, 1, 1, 0);
        sweep();
        // R11: untagged instance
        op(1, 'h5, 1, 0, 'h33, 0, 0, 0);
        u_look('h5, 2, 1, 'h33, "R11 pid ignored");
        op(1, 'h5, 3, 1, 'h44, 0, 0, 0);
        u_look('h5, 0, 1, 'h44, "R11 overwrite by page");
        op(1, 'h6, 0, 0, 'h46, 0, 0, 0);
        op(1, 'h7, 0, 0, 'h47, 0, 0, 0);
        u_look('h5, 1, 1, 'h44, "R11 no eviction");
        u_look('h7, 3, 1, 'h47, "R11 third slot");
        op(0, 0, 0, 0, 0, 0, 1, 0);
        u_look('h5, 0, 0, 0, "R11 flush clears all");
        u_look('h6, 1, 0, 0, "R11 flush clears all");
        u_look('h7, 2, 0, 0, "R11 flush clears all");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule